// File: doc/BRIEF.md
# Floating-Point Register Write Reservation Scoreboard

This block tracks which floating-point registers still await a result from an ALU operation already in flight. It holds one reservation bit per register. An ALU operation sets the bit of its destination when it issues. Because every functional unit has the same fixed latency, the block retires each reservation by itself: an internal delay line carries the destination index and clears the bit exactly `LATENCY` cycles after the set.

Two combinational lookups serve the source operands of the ALU issue stage, and a third serves the register operand of a load or store. An ALU request whose sources are reserved is held with `alu_stall_o`. A load or store whose register is reserved is held with `ls_stall_o`, so that a register is neither read nor overwritten before its pending result lands. A flush drops every reservation and every retirement still in the delay line.

Top module: `fp_resv_scoreboard`

## Requirements
- R1: After reset, no register is reserved. Every lookup on indices 0 to 51 reports free.
- R2: When `alu_issue_o` is high at a clock edge, the bit of `alu_dst_i` is set. Lookups see this bit from the next cycle on, and not in the issue cycle itself.
- R3: A reservation made at edge E stays visible for the three cycles after E and is cleared by edge E+3. Lookups in the cycle after E+3 report the register free.
- R4: `alu_stall_o` is high exactly when `alu_req_i` is high and the register named by `alu_src_a_i` or the register named by `alu_src_b_i` is reserved. `alu_issue_o` equals `alu_req_i & ~alu_stall_o & ~flush_i`.
- R5: `ls_stall_o` is high exactly when `ls_req_i` is high and the register named by `ls_reg_i` is reserved.
- R6: If a new issue sets a register in the same cycle that an older reservation of that register retires, the bit stays set. It is then cleared three cycles after the new set.
- R7: A retiring reservation does not clear the bit while a younger issue to the same register is still in the delay line. The bit clears only when the youngest writer retires.
- R8: A high `flush_i` clears every bit and empties the delay line at the next edge. No issue happens in a flush cycle.
- R9: Register indices 52 to 63 are not tracked. Lookups on them always report free, and issuing to them reserves nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop all reservations and pending retirements |
| alu_req_i | input | 1 | An ALU operation or vector element requests issue |
| alu_src_a_i | input | 6 | First source register index |
| alu_src_b_i | input | 6 | Second source register index |
| alu_dst_i | input | 6 | Destination register index |
| alu_stall_o | output | 1 | ALU request held because a source is reserved |
| alu_issue_o | output | 1 | ALU request issues this cycle and reserves its destination |
| ls_req_i | input | 1 | A load or store requests issue |
| ls_reg_i | input | 6 | Load/store register index |
| ls_stall_o | output | 1 | Load/store held because its register is reserved |

## Verification
The bench builds the block with its default parameters: 52 tracked registers, a 6-bit index and a three-cycle latency. The short latency makes overlap cases easy to reach within a few cycles. These include a second writer to the same register that issues one cycle or exactly three cycles after the first, a flush that lands while a retirement is in flight, and lookups on the unused indices above 51. All of them are driven directly at the ports, and each one's effect on the stall outputs is observed cycle by cycle.

// File: rtl/fp_resv_pkg.sv
package fp_resv_pkg;
  localparam int unsigned RESV_REGS   = 52;
  localparam int unsigned RESV_ADDR_W = 6;
  localparam int unsigned RESV_LAT    = 3;
  localparam int unsigned RESV_SPAN   = 1 << RESV_ADDR_W;

  typedef logic [RESV_ADDR_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     vld;
    reg_idx_t idx;
  } retire_ent_t;
endpackage

// File: rtl/resv_retire_pipe.sv
module resv_retire_pipe
  import fp_resv_pkg::*;
#(
  parameter int unsigned LATENCY = RESV_LAT
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     flush_i,
  input  logic     push_i,
  input  reg_idx_t push_idx_i,
  output logic     clr_vld_o,
  output reg_idx_t clr_idx_o
);
  localparam int unsigned LAST = LATENCY - 1;

  retire_ent_t stage_q [LATENCY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LATENCY; i++) stage_q[i] <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < LATENCY; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= '{vld: push_i, idx: push_idx_i};
      for (int i = 1; i < LATENCY; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  // a younger writer of the same register keeps the reservation alive
  logic younger_hit;
  always_comb begin
    younger_hit = 1'b0;
    for (int i = 0; i < LAST; i++) begin
      if (stage_q[i].vld && stage_q[i].idx == stage_q[LAST].idx) younger_hit = 1'b1;
    end
  end

  assign clr_vld_o = stage_q[LAST].vld && !younger_hit;
  assign clr_idx_o = stage_q[LAST].idx;
endmodule

// File: rtl/resv_bit_array.sv
module resv_bit_array
  import fp_resv_pkg::*;
#(
  parameter int unsigned NUM_REGS = RESV_REGS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                set_vld_i,
  input  reg_idx_t            set_idx_i,
  input  logic                clr_vld_i,
  input  reg_idx_t            clr_idx_i,
  output logic [NUM_REGS-1:0] busy_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    localparam reg_idx_t MY_IDX = reg_idx_t'(g);
    logic set_hit, clr_hit, bit_q;

    assign set_hit = set_vld_i && set_idx_i == MY_IDX;
    assign clr_hit = clr_vld_i && clr_idx_i == MY_IDX;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bit_q <= 1'b0;
      else if (flush_i) bit_q <= 1'b0;
      else if (set_hit) bit_q <= 1'b1;  // set wins over a same-cycle clear
      else if (clr_hit) bit_q <= 1'b0;
    end

    assign busy_o[g] = bit_q;
  end
endmodule

// File: rtl/resv_lookup.sv
module resv_lookup
  import fp_resv_pkg::*;
#(
  parameter int unsigned NUM_REGS = RESV_REGS
) (
  input  logic [NUM_REGS-1:0] busy_i,
  input  logic                req_i,
  input  reg_idx_t            idx_i,
  output logic                hit_o
);
  localparam int unsigned PAD = RESV_SPAN - NUM_REGS;

  logic [RESV_SPAN-1:0] busy_pad;

  if (PAD > 0) begin : g_pad
    assign busy_pad = {{PAD{1'b0}}, busy_i};
  end else begin : g_nopad
    assign busy_pad = busy_i;
  end

  assign hit_o = req_i && busy_pad[idx_i];
endmodule

// File: rtl/fp_resv_scoreboard.sv
module fp_resv_scoreboard
  import fp_resv_pkg::*;
#(
  parameter int unsigned NUM_REGS = RESV_REGS,
  parameter int unsigned LATENCY  = RESV_LAT
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   alu_req_i,
  input  logic [RESV_ADDR_W-1:0] alu_src_a_i,
  input  logic [RESV_ADDR_W-1:0] alu_src_b_i,
  input  logic [RESV_ADDR_W-1:0] alu_dst_i,
  output logic                   alu_stall_o,
  output logic                   alu_issue_o,
  input  logic                   ls_req_i,
  input  logic [RESV_ADDR_W-1:0] ls_reg_i,
  output logic                   ls_stall_o
);
  localparam int unsigned NUM_LOOKUPS = 3;

  logic [NUM_REGS-1:0] busy_w;
  logic                clr_vld;
  reg_idx_t            clr_idx;
  logic                lk_req [NUM_LOOKUPS];
  reg_idx_t            lk_idx [NUM_LOOKUPS];
  logic                lk_hit [NUM_LOOKUPS];

  assign lk_req[0] = alu_req_i;
  assign lk_idx[0] = alu_src_a_i;
  assign lk_req[1] = alu_req_i;
  assign lk_idx[1] = alu_src_b_i;
  assign lk_req[2] = ls_req_i;
  assign lk_idx[2] = ls_reg_i;

  for (genvar g = 0; g < NUM_LOOKUPS; g++) begin : g_lookup
    resv_lookup #(.NUM_REGS(NUM_REGS)) u_lookup (
      .busy_i (busy_w),
      .req_i  (lk_req[g]),
      .idx_i  (lk_idx[g]),
      .hit_o  (lk_hit[g])
    );
  end

  assign alu_stall_o = lk_hit[0] || lk_hit[1];
  assign ls_stall_o  = lk_hit[2];
  assign alu_issue_o = alu_req_i && !alu_stall_o && !flush_i;

  resv_retire_pipe #(.LATENCY(LATENCY)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .push_i     (alu_issue_o),
    .push_idx_i (alu_dst_i),
    .clr_vld_o  (clr_vld),
    .clr_idx_o  (clr_idx)
  );

  resv_bit_array #(.NUM_REGS(NUM_REGS)) u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .set_vld_i (alu_issue_o),
    .set_idx_i (alu_dst_i),
    .clr_vld_i (clr_vld),
    .clr_idx_i (clr_idx),
    .busy_o    (busy_w)
  );
endmodule

// File: rtl/fp_resv_scoreboard_chk.sv
module fp_resv_scoreboard_chk
  import fp_resv_pkg::*;
#(
  parameter int unsigned NUM_REGS = RESV_REGS
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   flush_i,
  input logic                   alu_req_i,
  input logic [RESV_ADDR_W-1:0] alu_dst_i,
  input logic                   alu_stall_o,
  input logic                   alu_issue_o,
  input logic                   ls_req_i,
  input logic [RESV_ADDR_W-1:0] ls_reg_i,
  input logic                   ls_stall_o,
  input logic [NUM_REGS-1:0]    busy_i
);
  a_r2_issue_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_issue_o && 32'(alu_dst_i) < NUM_REGS) |=> busy_i[$past(alu_dst_i)]);

  a_r4_no_stall_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_req_i |-> !alu_stall_o);

  a_r4_issue_not_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_issue_o |-> (alu_req_i && !alu_stall_o));

  a_r5_ls_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ls_req_i |-> !ls_stall_o);

  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (busy_i == '0));

  a_r9_untracked_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_req_i && 32'(ls_reg_i) >= NUM_REGS) |-> !ls_stall_o);
endmodule

bind fp_resv_scoreboard fp_resv_scoreboard_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .alu_req_i   (alu_req_i),
  .alu_dst_i   (alu_dst_i),
  .alu_stall_o (alu_stall_o),
  .alu_issue_o (alu_issue_o),
  .ls_req_i    (ls_req_i),
  .ls_reg_i    (ls_reg_i),
  .ls_stall_o  (ls_stall_o),
  .busy_i      (busy_w)
);

// File: tb/fp_resv_scoreboard_test.sv
`timescale 1ns/1ps
module fp_resv_scoreboard_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flush_i = 1'b0;
  logic       alu_req_i = 1'b0;
  logic [5:0] alu_src_a_i = '0, alu_src_b_i = '0, alu_dst_i = '0;
  logic       alu_stall_o, alu_issue_o;
  logic       ls_req_i = 1'b0;
  logic [5:0] ls_reg_i = '0;
  logic       ls_stall_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fp_resv_scoreboard uut (.*);

  // {alu_req, src_a, src_b, dst, ls_req, ls_reg, exp_alu_stall, exp_ls_stall}
  localparam int VW = 28;
  localparam logic [VW-1:0] VEC [12] = '{
    {1'b1, 6'd1,  6'd2,  6'd10, 1'b1, 6'd10, 1'b0, 1'b0},
    {1'b1, 6'd10, 6'd3,  6'd11, 1'b1, 6'd10, 1'b1, 1'b1},
    {1'b0, 6'd0,  6'd0,  6'd0,  1'b1, 6'd10, 1'b0, 1'b1},
    {1'b0, 6'd0,  6'd0,  6'd0,  1'b1, 6'd10, 1'b0, 1'b1},
    {1'b1, 6'd10, 6'd10, 6'd10, 1'b1, 6'd10, 1'b0, 1'b0},
    {1'b1, 6'd20, 6'd21, 6'd20, 1'b1, 6'd10, 1'b0, 1'b1},
    {1'b1, 6'd0,  6'd20, 6'd5,  1'b1, 6'd20, 1'b1, 1'b1},
    {1'b1, 6'd0,  6'd0,  6'd20, 1'b1, 6'd10, 1'b0, 1'b1},
    {1'b0, 6'd0,  6'd0,  6'd0,  1'b1, 6'd10, 1'b0, 1'b0},
    {1'b1, 6'd20, 6'd1,  6'd7,  1'b1, 6'd20, 1'b1, 1'b1},
    {1'b0, 6'd0,  6'd0,  6'd0,  1'b1, 6'd20, 1'b0, 1'b1},
    {1'b1, 6'd20, 6'd20, 6'd7,  1'b1, 6'd20, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  // drive at the falling edge, settle, then return for checks
  task automatic apply(input logic fl, input logic ar, input logic [5:0] a, input logic [5:0] b,
                       input logic [5:0] d, input logic lr, input logic [5:0] l);
    @(negedge clk_i);
    flush_i = fl; alu_req_i = ar; alu_src_a_i = a; alu_src_b_i = b; alu_dst_i = d;
    ls_req_i = lr; ls_reg_i = l;
    #2;
  endtask

  task automatic ls_probe(input string req, input logic [5:0] l, input logic exp);
    apply(1'b0, 1'b0, 6'd0, 6'd0, 6'd0, 1'b1, l);
    chk(req, ls_stall_o, exp);
  endtask

  task automatic issue(input string req, input logic [5:0] d);
    apply(1'b0, 1'b1, 6'd0, 6'd0, d, 1'b0, 6'd0);
    chk(req, alu_issue_o, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: nothing reserved after reset
    for (int r = 0; r < 52; r++) ls_probe("R1", 6'(r), 1'b0);
    apply(1'b0, 1'b1, 6'd51, 6'd0, 6'd0, 1'b0, 6'd0);
    chk("R1", alu_stall_o, 1'b0);
    apply(1'b0, 1'b0, 6'd0, 6'd0, 6'd0, 1'b0, 6'd0);

    // R2 R3 R4 R5: table walk
    for (int i = 0; i < 12; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(1'b0, v[27], v[26:21], v[20:15], v[14:9], v[8], v[7:2]);
      chk("R4 alu stall", alu_stall_o, v[1]);
      chk("R5 ls stall", ls_stall_o, v[0]);
      chk("R4 issue", alu_issue_o, v[27] & ~v[1]);
    end
    repeat (4) apply(1'b0, 1'b0, 6'd0, 6'd0, 6'd0, 1'b0, 6'd0);

    // R6: re-issue to same register exactly when the old one retires
    issue("R6", 6'd30);
    ls_probe("R3", 6'd30, 1'b1);
    ls_probe("R3", 6'd30, 1'b1);
    apply(1'b0, 1'b1, 6'd0, 6'd0, 6'd30, 1'b1, 6'd30);
    chk("R3", ls_stall_o, 1'b1);
    chk("R6", alu_issue_o, 1'b1);
    ls_probe("R6", 6'd30, 1'b1);
    ls_probe("R6", 6'd30, 1'b1);
    ls_probe("R6", 6'd30, 1'b1);
    ls_probe("R6", 6'd30, 1'b0);

    // R7: back-to-back writers, older retirement must not free the register
    issue("R7", 6'd31);
    issue("R7", 6'd31);
    ls_probe("R7", 6'd31, 1'b1);
    ls_probe("R7", 6'd31, 1'b1);
    ls_probe("R7", 6'd31, 1'b1);
    ls_probe("R7", 6'd31, 1'b0);

    // R8: flush drops reservations and blocks issue
    issue("R8", 6'd40);
    apply(1'b1, 1'b1, 6'd0, 6'd0, 6'd41, 1'b1, 6'd40);
    chk("R8 issue", alu_issue_o, 1'b0);
    ls_probe("R8", 6'd40, 1'b0);
    ls_probe("R8", 6'd41, 1'b0);
    apply(1'b0, 1'b1, 6'd40, 6'd41, 6'd2, 1'b0, 6'd0);
    chk("R8 alu", alu_stall_o, 1'b0);

    // R9: untracked indices
    apply(1'b0, 1'b1, 6'd0, 6'd0, 6'd55, 1'b1, 6'd55);
    chk("R9 issue", alu_issue_o, 1'b1);
    chk("R9 ls", ls_stall_o, 1'b0);
    apply(1'b0, 1'b1, 6'd55, 6'd63, 6'd3, 1'b1, 6'd55);
    chk("R9 alu", alu_stall_o, 1'b0);
    chk("R9 ls", ls_stall_o, 1'b0);
    apply(1'b0, 1'b0, 6'd0, 6'd0, 6'd0, 1'b0, 6'd0);

    finish_run();
  end
endmodule